// File: doc/BRIEF.md
# Fuse Array Auto-Read Sequencer

This block reads a single 32-bit word out of a one-time-programmable fuse macro in response to one register write. Software places a 10-bit word address, a read bit and an enable bit into the command register. The block then runs the macro through a timed read sequence without further software involvement. First the macro is selected with load raised and programming held off. Next the address is presented, and after that strobe is pulsed. The word is captured at the end of the strobe window. Capture raises a finish flag, which software clears by writing a one to it.

Each wait in the sequence lasts a whole number of clock cycles. That number is derived from the clock frequency parameter so that every interval is at least one microsecond. The finish flag is set after three intervals, which keeps it inside a four-microsecond budget. The block then holds the macro through a fourth, recovery interval before it puts the macro back into standby (deselected and powered down). It accepts a new command only after that. A command that arrives during a read is dropped.

Top module: `fuse_autord`

## Requirements
- R1: After reset the status, data-out and command registers read as zero. The macro sits in standby: chip-select-low output high, power-down high, program-enable-low output high, load low, strobe low, address zero.
- R2: A write to offset 0x24 with bit 0 (enable) and bit 1 (read) both set starts a read of the word address in bits 25:16; other bits are ignored. While a read runs, reading 0x24 returns 1 in bits 1:0 and the latched address in bits 25:16.
- R3: A write to 0x24 that lacks bit 0 or bit 1 starts nothing: pins stay in standby, the finish flag stays clear and data-out keeps its value.
- R4: With W = wait cycles, the register edge that accepts a command starts a fixed schedule. For W cycles the macro is selected with load high and the address bus zero. For the next W cycles the address is driven. For the next W cycles strobe is high. For the last W cycles strobe is low with the address still driven.
- R5: The program-enable-low output stays high throughout every read.
- R6: The word on the macro's data input at the last strobe-high cycle is stored in data-out (offset 0x20).
- R7: Bit 0 of status (offset 0x18) becomes 1 exactly 3*W cycles after the accepting edge, which is at most 4 µs.
- R8: Writing status with bit 0 set clears the finish flag. Writing it with bit 0 clear leaves the flag as it is. A capture in the same cycle as a clear wins.
- R9: A command written while a read is in progress, including in its last busy cycle, is ignored. Data-out holds its previous value until the next capture.
- R10: After the recovery interval the macro returns to standby, and a command written in the very next cycle is accepted.
- R11: W equals the clock frequency in Hz divided by 10^6, rounded up (100 at the default 100 MHz).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_req_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | Write when high, read when low |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| fuse_csn_o | output | 1 | Macro chip select, active low |
| fuse_pd_o | output | 1 | Macro power-down |
| fuse_pgmn_o | output | 1 | Macro program enable, active low |
| fuse_load_o | output | 1 | Macro load |
| fuse_strobe_o | output | 1 | Macro read strobe |
| fuse_addr_o | output | 10 | Macro word address |
| fuse_dout_i | input | 32 | Macro data output |

## Verification
The command table includes accepted commands at the lowest word address, the highest one and mid-range addresses, with stray bits set above and below the address field. These show that only bits 25:16 reach the macro. Commands with only one of the two start bits, or with neither, show that the start decode needs both bits. The behavioural fuse model drives a distinct word per address only while strobe is high and the macro is selected. A capture taken in the wrong cycle or from the wrong address therefore shows up as a wrong data-out value. Directed runs inject commands mid-read and in the last busy cycle, and then relaunch in the first idle cycle, to separate "ignored" from "accepted late".

// File: rtl/fuse_rd_pkg.sv
package fuse_rd_pkg;

  localparam logic [7:0] OFF_STAT = 8'h18;
  localparam logic [7:0] OFF_DOUT = 8'h20;
  localparam logic [7:0] OFF_CTRL = 8'h24;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_RD_BIT   = 1;
  localparam int CTRL_ADDR_LSB = 16;
  localparam int STAT_FIN_BIT  = 0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_ADDR,
    ST_STRB,
    ST_HOLD
  } seq_st_e;

  typedef struct packed {
    logic csn;
    logic pd;
    logic pgmn;
    logic load;
    logic strobe;
  } fuse_pins_t;

  localparam fuse_pins_t PINS_STANDBY = '{csn: 1'b1, pd: 1'b1, pgmn: 1'b1, load: 1'b0, strobe: 1'b0};

endpackage

// File: rtl/fuse_rd_regs.sv
module fuse_rd_regs
  import fuse_rd_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_req_i,
  input  logic              reg_we_i,
  input  logic [7:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              busy_i,
  input  logic [ADDR_W-1:0] cur_addr_i,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] cap_data_i,
  output logic              launch_o,
  output logic [ADDR_W-1:0] launch_addr_o
);

  logic              wr_stat, wr_ctrl;
  logic              finish_q;
  logic [DATA_W-1:0] dout_q;
  logic [DATA_W-1:0] ctrl_rd;
  logic              unused_wdata;

  assign wr_stat = reg_req_i && reg_we_i && (reg_addr_i == OFF_STAT);
  assign wr_ctrl = reg_req_i && reg_we_i && (reg_addr_i == OFF_CTRL);

  assign launch_o      = wr_ctrl && reg_wdata_i[CTRL_EN_BIT] && reg_wdata_i[CTRL_RD_BIT] && !busy_i;
  assign launch_addr_o = reg_wdata_i[CTRL_ADDR_LSB +: ADDR_W];
  assign unused_wdata  = ^reg_wdata_i;

  // capture beats a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      finish_q <= 1'b0;
    end else if (cap_i) begin
      finish_q <= 1'b1;
    end else if (wr_stat && reg_wdata_i[STAT_FIN_BIT]) begin
      finish_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q <= '0;
    end else if (cap_i) begin
      dout_q <= cap_data_i;
    end
  end

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[CTRL_ADDR_LSB +: ADDR_W] = cur_addr_i;
    ctrl_rd[CTRL_EN_BIT] = busy_i;
    ctrl_rd[CTRL_RD_BIT] = busy_i;
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      OFF_STAT: reg_rdata_o[STAT_FIN_BIT] = finish_q;
      OFF_DOUT: reg_rdata_o = dout_q;
      OFF_CTRL: reg_rdata_o = ctrl_rd;
      default:  reg_rdata_o = '0;
    endcase
  end

  AST_FIN_FROM_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(finish_q) |-> $past(cap_i)); // R7

  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat && reg_wdata_i[STAT_FIN_BIT] && !cap_i) |=> !finish_q); // R8

  AST_DOUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(dout_q)); // R9

endmodule

// File: rtl/fuse_rd_seq.sv
module fuse_rd_seq
  import fuse_rd_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 32,
  parameter int WAIT_CYC = 100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic [ADDR_W-1:0] launch_addr_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic              cap_o,
  output logic [DATA_W-1:0] cap_data_o,
  output fuse_pins_t        pins_o,
  output logic [ADDR_W-1:0] fuse_addr_o,
  input  logic [DATA_W-1:0] fuse_dout_i
);

  localparam int              CNT_W    = $clog2(WAIT_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WAIT_CYC - 1);

  seq_st_e           st_q, st_nxt;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic              cnt_done;

  assign cnt_done = (cnt_q == '0);

  always_comb begin
    case (st_q)
      ST_LOAD: st_nxt = ST_ADDR;
      ST_ADDR: st_nxt = ST_STRB;
      ST_STRB: st_nxt = ST_HOLD;
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      addr_q <= '0;
    end else if (st_q == ST_IDLE) begin
      if (launch_i) begin
        st_q   <= ST_LOAD;
        cnt_q  <= CNT_LOAD;
        addr_q <= launch_addr_i;
      end
    end else if (cnt_done) begin
      st_q  <= st_nxt;
      cnt_q <= (st_nxt == ST_IDLE) ? '0 : CNT_LOAD;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_comb begin
    pins_o      = PINS_STANDBY;
    fuse_addr_o = '0;
    case (st_q)
      ST_LOAD: begin
        pins_o.csn  = 1'b0;
        pins_o.pd   = 1'b0;
        pins_o.load = 1'b1;
      end
      ST_ADDR, ST_HOLD: begin
        pins_o.csn  = 1'b0;
        pins_o.pd   = 1'b0;
        pins_o.load = 1'b1;
        fuse_addr_o = addr_q;
      end
      ST_STRB: begin
        pins_o.csn    = 1'b0;
        pins_o.pd     = 1'b0;
        pins_o.load   = 1'b1;
        pins_o.strobe = 1'b1;
        fuse_addr_o   = addr_q;
      end
      default: ;
    endcase
  end

  assign busy_o     = (st_q != ST_IDLE);
  assign cur_addr_o = addr_q;
  assign cap_o      = (st_q == ST_STRB) && cnt_done;
  assign cap_data_o = fuse_dout_i;

  AST_LAUNCH_ONLY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i |-> (st_q == ST_IDLE)); // R9

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_LOAD); // R11

  AST_STROBE_ADDR_SETTLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pins_o.strobe) |-> (fuse_addr_o == $past(fuse_addr_o))); // R4

endmodule

// File: rtl/fuse_autord.sv
module fuse_autord
  import fuse_rd_pkg::*;
#(
  parameter int CLK_FREQ_HZ = 100_000_000,
  parameter int FUSE_AW     = 10,
  parameter int FUSE_DW     = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_req_i,
  input  logic               reg_we_i,
  input  logic [7:0]         reg_addr_i,
  input  logic [FUSE_DW-1:0] reg_wdata_i,
  output logic [FUSE_DW-1:0] reg_rdata_o,
  output logic               fuse_csn_o,
  output logic               fuse_pd_o,
  output logic               fuse_pgmn_o,
  output logic               fuse_load_o,
  output logic               fuse_strobe_o,
  output logic [FUSE_AW-1:0] fuse_addr_o,
  input  logic [FUSE_DW-1:0] fuse_dout_i
);

  localparam int WAIT_CYC = (CLK_FREQ_HZ + 999_999) / 1_000_000;

  logic               busy, launch, cap;
  logic [FUSE_AW-1:0] launch_addr, cur_addr;
  logic [FUSE_DW-1:0] cap_data;
  fuse_pins_t         pins;

  fuse_rd_regs #(
    .ADDR_W(FUSE_AW),
    .DATA_W(FUSE_DW)
  ) regs_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .reg_req_i     (reg_req_i),
    .reg_we_i      (reg_we_i),
    .reg_addr_i    (reg_addr_i),
    .reg_wdata_i   (reg_wdata_i),
    .reg_rdata_o   (reg_rdata_o),
    .busy_i        (busy),
    .cur_addr_i    (cur_addr),
    .cap_i         (cap),
    .cap_data_i    (cap_data),
    .launch_o      (launch),
    .launch_addr_o (launch_addr)
  );

  fuse_rd_seq #(
    .ADDR_W  (FUSE_AW),
    .DATA_W  (FUSE_DW),
    .WAIT_CYC(WAIT_CYC)
  ) seq_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .launch_i      (launch),
    .launch_addr_i (launch_addr),
    .busy_o        (busy),
    .cur_addr_o    (cur_addr),
    .cap_o         (cap),
    .cap_data_o    (cap_data),
    .pins_o        (pins),
    .fuse_addr_o   (fuse_addr_o),
    .fuse_dout_i   (fuse_dout_i)
  );

  assign fuse_csn_o    = pins.csn;
  assign fuse_pd_o     = pins.pd;
  assign fuse_pgmn_o   = pins.pgmn;
  assign fuse_load_o   = pins.load;
  assign fuse_strobe_o = pins.strobe;

  AST_STROBE_SELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fuse_strobe_o |-> (!fuse_csn_o && fuse_load_o && fuse_pgmn_o && !fuse_pd_o)); // R5

endmodule

// File: tb/fuse_autord_tb_top.sv
module fuse_autord_tb_top;

  localparam int          FREQ = 100_000_000;
  localparam int          W    = (FREQ + 999_999) / 1_000_000;
  localparam logic [7:0]  A_ST = 8'h18;
  localparam logic [7:0]  A_DO = 8'h20;
  localparam logic [7:0]  A_CT = 8'h24;

  // command words: launch iff bits 1:0 == 2'b11, address bits 25:16
  localparam logic [31:0] VEC [8] = '{
    32'h0000_0003, 32'h03FF_0003, 32'h0155_0001, 32'h02AA_0002,
    32'hFC12_3403, 32'h0000_0000, 32'h0201_FFFF, 32'h0155_0003
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        csn, pd, pgmn, load, strobe;
  logic [9:0]  faddr;
  logic [31:0] fdout;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;
  logic [31:0] prev = '0;
  logic [31:0] rd;

  always #5 clk = ~clk;

  function automatic logic [31:0] fw(input logic [9:0] a);
    return (32'h9E37_79B1 * {22'd0, a} + 32'h1234_5678) ^ {a, 22'h2A5A5};
  endfunction

  assign fdout = (!csn && !pd && pgmn && load && strobe) ? fw(faddr) : 32'h0;

  fuse_autord #(.CLK_FREQ_HZ(FREQ)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_req_i(req), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .fuse_csn_o(csn), .fuse_pd_o(pd), .fuse_pgmn_o(pgmn), .fuse_load_o(load),
    .fuse_strobe_o(strobe), .fuse_addr_o(faddr), .fuse_dout_i(fdout)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0; wdata = '0;
  endtask

  task automatic reg_rd(input logic [7:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    req = 1'b0;
  endtask

  function automatic bit standby();
    return csn && pd && pgmn && !load && !strobe && (faddr == '0);
  endfunction

  // called at the negedge right after the accepting edge (n = 0)
  task automatic run_window(input logic [9:0] a, input int inj_n, input logic [31:0] inj_d,
                            input bit fin_pre);
    int e_ld = 0, e_ad = 0, e_sb = 0, e_ho = 0, e_pg = 0, e_fin = 0;
    for (int n = 0; n < 4 * W; n++) begin
      if (n == inj_n) begin
        req = 1'b1; we = 1'b1; addr = A_CT; wdata = inj_d;
      end else begin
        req = 1'b0; we = 1'b0; addr = A_ST; wdata = '0;
      end
      #1;
      if (!pgmn) e_pg++;
      if (n < W) begin
        if (csn || pd || !load || strobe || faddr != '0) e_ld++;
      end else if (n < 2 * W) begin
        if (csn || pd || !load || strobe || faddr != a) e_ad++;
      end else if (n < 3 * W) begin
        if (csn || pd || !load || !strobe || faddr != a) e_sb++;
      end else begin
        if (csn || pd || !load || strobe || faddr != a) e_ho++;
      end
      if (n != inj_n) begin
        if (n >= 3 * W && !rdata[0]) e_fin++;
        if (n < 3 * W && fin_pre && rdata[0]) e_fin++;
      end
      @(negedge clk);
    end
    req = 1'b0; we = 1'b0; wdata = '0;
    chk(e_ld == 0, "R4 load phase", e_ld, 0);
    chk(e_ad == 0, "R4 address phase", e_ad, 0);
    chk(e_sb == 0, "R4 strobe phase", e_sb, 0);
    chk(e_ho == 0, "R4 hold phase", e_ho, 0);
    chk(e_pg == 0, "R5 program-enable high", e_pg, 0);
    chk(e_fin == 0, "R7 finish timing", e_fin, 0);
    #1 chk(standby(), "R10 standby after recovery", {csn, pd, pgmn, load, strobe}, 5'b11100);
  endtask

  initial begin
    repeat (200_000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=%h exp=%h", 32'd1, 32'd0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(standby(), "R1 pins at reset", {csn, pd, pgmn, load, strobe}, 5'b11100);
    reg_rd(A_ST, rd); chk(rd == 0, "R1 status reset", rd, 0);
    reg_rd(A_DO, rd); chk(rd == 0, "R1 dout reset", rd, 0);
    reg_rd(A_CT, rd); chk(rd == 0, "R1 ctrl reset", rd, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(W == 100 && 3 * W <= 400, "R11 wait cycles from 100 MHz", W, 100);

    foreach (VEC[i]) begin
      logic [31:0] d = VEC[i];
      logic [9:0]  a = d[25:16];
      reg_wr(A_CT, d);
      if (d[1:0] == 2'b11) begin
        reg_rd(A_CT, rd);
        chk(rd == {6'd0, a, 14'd0, 2'b11}, "R2 busy readback", rd, {6'd0, a, 14'd0, 2'b11});
        run_window(a, -1, '0, 1'b1);
        reg_rd(A_DO, rd); chk(rd == fw(a), "R6 captured word", rd, fw(a));
        prev = fw(a);
        @(negedge clk);
        reg_wr(A_ST, 32'h1);
        reg_rd(A_ST, rd); chk(rd == 0, "R8 clear after read", rd, 0);
      end else begin
        repeat (5) @(negedge clk);
        #1 chk(standby(), "R3 no launch pins", {csn, pd, pgmn, load, strobe}, 5'b11100);
        reg_rd(A_ST, rd); chk(rd == 0, "R3 no finish", rd, 0);
        reg_rd(A_DO, rd); chk(rd == prev, "R3 dout kept", rd, prev);
        @(negedge clk);
      end
    end

    // R9: dout holds old value mid-read; flag kept until explicitly cleared (R8)
    reg_wr(A_CT, {6'd0, 10'h0AB, 16'h0003});
    repeat (5) @(negedge clk);
    reg_rd(A_DO, rd); chk(rd == prev, "R9 dout held during read", rd, prev);
    repeat (4 * W) @(negedge clk);
    reg_rd(A_DO, rd); chk(rd == fw(10'h0AB), "R6 word at 0x0AB", rd, fw(10'h0AB));
    reg_wr(A_ST, 32'h0);
    reg_rd(A_ST, rd); chk(rd == 1, "R8 write zero keeps flag", rd, 1);
    @(negedge clk);
    reg_wr(A_ST, 32'h2);
    reg_rd(A_ST, rd); chk(rd == 1, "R8 other bit keeps flag", rd, 1);
    @(negedge clk);
    reg_wr(A_ST, 32'h1);
    reg_rd(A_ST, rd); chk(rd == 0, "R8 write one clears", rd, 0);
    @(negedge clk);

    // R9: mid-read command ignored; then last-busy-cycle command ignored, R10 immediate relaunch
    reg_wr(A_CT, {6'd0, 10'h155, 16'h0003});
    run_window(10'h155, 2 * W + 3, {6'd0, 10'h2AA, 16'h0003}, 1'b1);
    reg_rd(A_CT, rd); chk(rd[25:16] == 10'h155, "R9 address unchanged", rd[25:16], 10'h155);
    reg_rd(A_DO, rd); chk(rd == fw(10'h155), "R9 word of first command", rd, fw(10'h155));
    reg_wr(A_ST, 32'h1);
    reg_wr(A_CT, {6'd0, 10'h311, 16'h0003});
    run_window(10'h311, 4 * W - 1, {6'd0, 10'h099, 16'h0003}, 1'b1);
    reg_wr(A_CT, {6'd0, 10'h222, 16'h0003});
    run_window(10'h222, -1, '0, 1'b0);
    reg_rd(A_DO, rd); chk(rd == fw(10'h222), "R10 immediate relaunch word", rd, fw(10'h222));

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule